// File: doc/BRIEF.md
# Lockstep Three-Stage Tagged Pipeline

This block carries a stream of 32-bit words through three fixed arithmetic stages placed between a small input queue and a small output queue. Every stage moves in the same clock step. Either the whole pipeline advances, or nothing inside it changes. Each of the two internal stage registers carries a valid tag. When no input word is waiting, an empty slot (bubble) enters the pipeline and the words already inside keep moving toward the output. The three stages compute `s0(x) = x + 1`, `s1(x) = x << 1` and `s2(x) = x ^ 0xA5A5A5A5`. These stand in for real datapath work.

Both edges of the block use a ready/valid stream. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high.

A small controller tracks which stages hold valid words. It has four named states:
- `OCC_NONE`: both stages empty.
- `OCC_S1`: only the first stage holds a word.
- `OCC_S2`: only the second stage holds a word.
- `OCC_BOTH`: both stages hold words.

On a step, the next state is formed by two rules. The first-stage tag takes "input queue non-empty", and the second-stage tag takes the old first-stage tag. This gives the transitions:
- Step with no input waiting: NONE→NONE, S1→S2, S2→NONE, BOTH→S2.
- Step with input waiting: NONE→S1, S1→BOTH, S2→S1, BOTH→BOTH.
- Stall: the state holds.

A stall happens only in `OCC_S2` or `OCC_BOTH` with the output queue full.

Top module: `pipe_sync3`

## Requirements
- R1: After synchronous active-high reset, `in_ready` is 1, `out_valid` is 0, and no result appears until a word has been accepted.
- R2: Every accepted word x produces exactly one result, `((x + 1) << 1) ^ 32'hA5A5A5A5` modulo 2^32. Results leave in the order the words were accepted, with none lost or duplicated.
- R3: The input queue holds 4 words. `in_ready` is low exactly when the queue is full. A word is taken only on an edge where both `in_valid` and `in_ready` are 1.
- R4: The output queue holds 4 results. `out_valid` is high exactly when the queue is non-empty. `out_data` shows the oldest result, and it is removed on an edge where both `out_ready` and `out_valid` are 1.
- R5: The pipeline steps whenever the second stage is empty or the output queue has space. A step is blocked only when the second stage is valid and the output queue is full. While blocked, no word leaves the input queue and both stages hold. With `out_ready` held low, exactly 10 words are accepted before `in_ready` falls (4 + 1 + 1 + 4).
- R6: An empty input queue does not block a step. A bubble enters the first stage and the words inside keep moving. A word accepted on edge k, with empty stages and an idle input, makes `out_valid` rise after edge k+3 and not before.
- R7: The second-stage tag copies the first-stage tag on every step. Only a valid second stage enqueues a result. Steps with an empty input and empty stages leave `out_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input queue has room |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output queue holds a result |
| out_ready | input | 1 | Consumer takes the head result |
| out_data | output | 32 | Oldest result |

## Verification
Two functions can fall in the same clock edge. A word can be pushed into the input queue on the same edge that a step pops its head. Likewise, the consumer can remove a result on the same edge that a step enqueues a new one.

The bench provokes both by sweeping sixteen combinations of input-gap density and output back-pressure density. A deterministic shift-register sequence picks the gaps and the stalls, so both queues repeatedly sit at full or empty while both of their ports are active.

Each delivered word is judged against a reference queue that holds the arithmetic expectation. Any loss, duplication, reordering or wrong value is reported at the moment it appears at `out_data`.

// File: rtl/pipe_sync3_pkg.sv
package pipe_sync3_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // bit 0: first stage valid, bit 1: second stage valid
    typedef enum logic [1:0] {
        OCC_NONE = 2'b00,
        OCC_S1   = 2'b01,
        OCC_S2   = 2'b10,
        OCC_BOTH = 2'b11
    } occ_t;

    function automatic word_t stage_a(input word_t x);
        return x + word_t'(1);
    endfunction

    function automatic word_t stage_b(input word_t x);
        return x << 1;
    endfunction

    function automatic word_t stage_c(input word_t x);
        return x ^ word_t'(32'hA5A5_A5A5);
    endfunction
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // R3 / R4: queue occupancy never passes its depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R4: a queue that is full and not popped stays full
    p_full_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
    import pipe_sync3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inq_nonempty,
    input  logic outq_full,
    output logic advance,
    output logic inq_pop,
    output logic outq_push,
    output logic s1_valid,
    output logic s2_valid
);
    occ_t state, state_next;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OCC_NONE;
        end else begin
            state <= state_next;
        end
    end

    // outputs decoded from the occupancy state
    always_comb begin
        s1_valid = 1'b0;
        s2_valid = 1'b0;
        unique case (state)
            OCC_NONE: begin s1_valid = 1'b0; s2_valid = 1'b0; end
            OCC_S1:   begin s1_valid = 1'b1; s2_valid = 1'b0; end
            OCC_S2:   begin s1_valid = 1'b0; s2_valid = 1'b1; end
            OCC_BOTH: begin s1_valid = 1'b1; s2_valid = 1'b1; end
            default:  begin s1_valid = 1'b0; s2_valid = 1'b0; end
        endcase
        advance   = !s2_valid || !outq_full;
        inq_pop   = advance && inq_nonempty;
        outq_push = advance && s2_valid;
    end

    // transitions: second tag takes first tag, first tag takes input presence
    always_comb begin
        state_next = state;
        if (advance) begin
            unique case (state)
                OCC_NONE: state_next = inq_nonempty ? OCC_S1   : OCC_NONE;
                OCC_S1:   state_next = inq_nonempty ? OCC_BOTH : OCC_S2;
                OCC_S2:   state_next = inq_nonempty ? OCC_S1   : OCC_NONE;
                OCC_BOTH: state_next = inq_nonempty ? OCC_BOTH : OCC_S2;
                default:  state_next = OCC_NONE;
            endcase
        end
    end

    // R6: a step with no input waiting leaves a bubble in the first stage
    p_bubble_in_r6: assert property (@(posedge clk) disable iff (rst)
        (advance && !inq_nonempty) |=> !s1_valid);

    // R7: the second tag follows the first on every step
    p_tag_copy_r7: assert property (@(posedge clk) disable iff (rst)
        advance |=> (s2_valid == $past(s1_valid)));

    // R5: a blocked step holds both tags
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(s1_valid) && $stable(s2_valid)));
endmodule

// File: rtl/stage_data.sv
module stage_data
    import pipe_sync3_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  logic  load,
    input  word_t head,
    output word_t result
);
    word_t s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else if (advance) begin
            if (load) begin
                s1_q <= stage_a(head);
            end
            s2_q <= stage_b(s1_q);
        end
    end

    assign result = stage_c(s2_q);
endmodule

// File: rtl/pipe_sync3.sv
module pipe_sync3
    import pipe_sync3_pkg::*;
#(
    parameter int unsigned QUEUE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    word_t inq_head, stage_out;
    logic  inq_full, inq_empty, outq_full, outq_empty;
    logic  advance, inq_pop, outq_push, s1_valid, s2_valid;

    word_fifo #(.WIDTH(WORD_W), .DEPTH(QUEUE_DEPTH)) u_inq (
        .clk(clk), .rst(rst),
        .push(in_valid), .push_data(in_data),
        .pop(inq_pop), .head(inq_head),
        .full(inq_full), .empty(inq_empty)
    );

    step_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .inq_nonempty(!inq_empty), .outq_full(outq_full),
        .advance(advance), .inq_pop(inq_pop), .outq_push(outq_push),
        .s1_valid(s1_valid), .s2_valid(s2_valid)
    );

    stage_data u_data (
        .clk(clk), .rst(rst),
        .advance(advance), .load(inq_pop),
        .head(inq_head), .result(stage_out)
    );

    word_fifo #(.WIDTH(WORD_W), .DEPTH(QUEUE_DEPTH)) u_outq (
        .clk(clk), .rst(rst),
        .push(outq_push), .push_data(stage_out),
        .pop(out_ready), .head(out_data),
        .full(outq_full), .empty(outq_empty)
    );

    assign in_ready  = !inq_full;
    assign out_valid = !outq_empty;

    // R5: nothing leaves the input queue while the full pipe is blocked
    p_no_drain_on_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (s2_valid && outq_full) |-> !inq_pop);

    // R7: an empty second stage never adds to the output queue
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        (!s2_valid && !out_ready && outq_empty) |=> outq_empty);
endmodule

// File: tb/sim_pipe_sync3.sv
module sim_pipe_sync3;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_ready = 1'b0;
    logic        in_ready, out_valid;
    logic [31:0] out_data;

    int unsigned checks = 0;
    int unsigned fails = 0;
    int unsigned cycles = 0;
    bit          done = 1'b0;
    logic [31:0] refq[$];
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] next_word = 32'h0000_0100;
    int unsigned accepted;

    always #4 clk = ~clk;

    pipe_sync3 u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [31:0] expect_of(input logic [31:0] x);
        return ((x + 32'd1) << 1) ^ 32'hA5A5_A5A5;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, judge handshakes, advance to next negedge
    task automatic step(input bit iv, input bit ordy);
        logic [31:0] exp;
        in_valid  = iv;
        in_data   = next_word;
        out_ready = ordy;
        #1;
        if (iv && in_ready) begin
            refq.push_back(expect_of(next_word));
            next_word = next_word * 32'd69069 + 32'd12345;
            accepted++;
        end
        if (out_valid && ordy) begin
            if (refq.size() == 0) begin
                check(1'b0, "R2 extra result", out_data, 32'h0);
            end else begin
                exp = refq.pop_front();
                check(out_data == exp, "R2 value/order", out_data, exp);
            end
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (refq.size() != 0 || out_valid); i++) begin
            step(1'b0, 1'b1);
        end
        check(refq.size() == 0, "R2 nothing lost", 32'(refq.size()), 32'd0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
        check(out_valid == 1'b0, "R7 no extra output", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R3 input free", 32'(in_ready), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        // R7 idle steps produce nothing
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
        check(out_valid == 1'b0, "R7 idle", 32'(out_valid), 32'd0);

        // R6 latency through bubbles: accept on edge k, visible after k+3
        accepted = 0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check(out_valid == 1'b0, "R6 after k+1", 32'(out_valid), 32'd0);
        step(1'b0, 1'b0);
        check(out_valid == 1'b0, "R6 after k+2", 32'(out_valid), 32'd0);
        step(1'b0, 1'b0);
        check(out_valid == 1'b1, "R6 after k+3", 32'(out_valid), 32'd1);
        check(out_data == refq[0], "R2 first value", out_data, refq[0]);
        drain();

        // R5 / R3 / R4 back-pressure capacity
        accepted = 0;
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
        check(accepted == 10, "R5 capacity", 32'(accepted), 32'd10);
        check(in_ready == 1'b0, "R3 in_ready low when full", 32'(in_ready), 32'd0);
        check(out_valid == 1'b1, "R4 out_valid", 32'(out_valid), 32'd1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        check(in_ready == 1'b0, "R5 stalled input held", 32'(in_ready), 32'd0);
        check(out_data == refq[0], "R4 head stable", out_data, refq[0]);
        drain();

        // near-exhaustive sweep: input gap density x back-pressure density
        for (int g = 0; g < 4; g++) begin
            for (int b = 0; b < 4; b++) begin
                for (int n = 0; n < 60; n++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    step(32'(lfsr[1:0]) >= g, 32'(lfsr[5:4]) >= b);
                end
                drain();
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 50000);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule